// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides when the analog-to-digital converter begins a conversion and tracks whether one is running. A conversion can begin in two ways. Software can write a one to a start bit. Alternatively, when auto-triggering is on, a rising edge on one of eight candidate trigger lines starts it; a 3-bit select field picks the line. A trigger start also sends a reset pulse to the clock prescaler, so that periodic triggers give conversions at fixed phase.

The converter core is modelled as a fixed run of `CONV_CYCLES` clock cycles that ends in a one-cycle completion strobe. While a conversion runs, the channel it uses is held in a latch. A new channel written during the conversion takes effect only when the next conversion starts. The latched channel drives the analog multiplexer, and a flag shows when the on-chip temperature sensor is the active input.

Clearing the enable bit aborts a running conversion without a completion strobe. It also blocks every way of starting a new one.

Top module: `adc_conv_starter`

## Requirements
- R1: After reset, `busy`, `conv_start`, `presc_rst`, `conv_done` and `sense_temp` are low and `conv_ch` is zero.
- R2: With `enable` high and no conversion running, a clock edge with `start_wr` high starts a conversion. From the next cycle, `busy` is high for exactly `CONV_CYCLES` cycles and `conv_start` is high for the first of them only. `conv_done` is high for one cycle, the first cycle in which `busy` is low again.
- R3: While `enable` is low, neither `start_wr` nor a trigger edge starts a conversion.
- R4: `conv_ch` takes the value of `ch_sel` when a conversion starts and holds it until the next start. A `ch_sel` change during a conversion has no effect on the running conversion.
- R5: With `auto_en` high, a rising edge on `trig_in[trig_sel]` starts a conversion, where `trig_sel` is the binary index of the line. `presc_rst` pulses in the same cycle as `conv_start`. A start caused only by `start_wr` leaves `presc_rst` low.
- R6: A rising trigger edge that arrives while a conversion runs is ignored. It neither restarts nor lengthens the conversion.
- R7: A trigger line still high when a conversion completes does not start another one. The line must go low and then rise again.
- R8: Edges on trigger lines other than the selected one, and any trigger edge while `auto_en` is low, start nothing.
- R9: Clearing `enable` during a conversion drops `busy` on the next cycle, and no `conv_done` strobe follows.
- R10: `sense_temp` is high exactly while `busy` is high and the latched channel equals the code 6'b100010.
- R11: `start_wr` during a running conversion does not restart it. The conversion still completes `CONV_CYCLES` cycles after its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low aborts and blocks conversions |
| start_wr | input | 1 | Software write of one to the start bit |
| auto_en | input | 1 | Auto-trigger enable |
| trig_sel | input | 3 | Index of the trigger line to watch |
| trig_in | input | 8 | Candidate trigger lines |
| ch_sel | input | 6 | Requested input channel |
| busy | output | 1 | Conversion in progress (readable start bit) |
| presc_rst | output | 1 | One-cycle prescaler reset on a trigger start |
| conv_ch | output | 6 | Channel latched for the active conversion |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_done | output | 1 | One-cycle completion strobe |
| sense_temp | output | 1 | Temperature sensor is the active input |

## Verification
The hardest case to reach is a trigger that stays high across the completion boundary. From the ports, that looks exactly like a fresh edge arriving in the cycle after `busy` falls. The bench raises the selected line to start a conversion and holds it high through all `CONV_CYCLES` cycles and several cycles after `conv_done`. It checks that no second start appears. It then drops the line for one cycle and raises it again, and confirms that this does start a conversion. A related case is an edge made inside the busy window by toggling the line mid-conversion. The bench checks that this edge neither produces a start pulse nor moves the completion cycle.

// File: rtl/adc_conv_starter.sv
module adc_conv_starter #(
  parameter int CONV_CYCLES = 13,
  parameter int TRIG_SEL_W  = 3,
  parameter int CH_W        = 6,
  parameter int TEMP_CH     = 34
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  start_wr,
  input  logic                  auto_en,
  input  logic [TRIG_SEL_W-1:0] trig_sel,
  input  logic [(1<<TRIG_SEL_W)-1:0] trig_in,
  input  logic [CH_W-1:0]       ch_sel,
  output logic                  busy,
  output logic                  presc_rst,
  output logic [CH_W-1:0]       conv_ch,
  output logic                  conv_start,
  output logic                  conv_done,
  output logic                  sense_temp
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CH_W-1:0]  TEMP_CODE = CH_W'(TEMP_CH);

  logic             trig_q;
  logic [CNT_W-1:0] cnt;

  wire trig_now  = trig_in[trig_sel];
  wire trig_rise = trig_now & ~trig_q;
  wire auto_go   = auto_en & trig_rise;
  wire go        = enable & ~busy & (start_wr | auto_go);
  wire last      = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q     <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      conv_ch    <= '0;
      conv_start <= 1'b0;
      presc_rst  <= 1'b0;
      conv_done  <= 1'b0;
    end else begin
      trig_q     <= trig_now;
      conv_start <= go;
      presc_rst  <= go & auto_go;
      conv_done  <= 1'b0;
      if (go) begin
        busy    <= 1'b1;
        cnt     <= CNT_LOAD;
        conv_ch <= ch_sel;
      end else if (busy) begin
        if (!enable) begin
          busy <= 1'b0;
        end else if (last) begin
          busy      <= 1'b0;
          conv_done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign sense_temp = busy & (conv_ch == TEMP_CODE);

  a_r2_sw_start: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !busy && start_wr) |=> (busy && conv_start));
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (!busy && $past(busy)));
  a_r3_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !conv_start);
  a_r4_ch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_start) |-> $stable(conv_ch));
  a_r5_presc_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    presc_rst |-> conv_start);
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !conv_start);
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !enable) |=> (!busy && !conv_done));
  a_r10_temp_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sense_temp |-> busy);

endmodule

// File: tb/adc_conv_starter_bench.sv
module adc_conv_starter_bench;
  localparam int CONV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, start_wr = 1'b0, auto_en = 1'b0;
  logic [2:0] trig_sel = '0;
  logic [7:0] trig_in = '0;
  logic [5:0] ch_sel = '0;
  logic busy, presc_rst, conv_start, conv_done, sense_temp;
  logic [5:0] conv_ch;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  adc_conv_starter #(.CONV_CYCLES(CONV)) u_adc_conv_starter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_wr(start_wr),
    .auto_en(auto_en), .trig_sel(trig_sel), .trig_in(trig_in), .ch_sel(ch_sel),
    .busy(busy), .presc_rst(presc_rst), .conv_ch(conv_ch),
    .conv_start(conv_start), .conv_done(conv_done), .sense_temp(sense_temp));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called one cycle after a start; n0 = busy cycles already seen
  task automatic finish_conv(input string tag, input int n0);
    int n = n0;
    bit idle = 0;
    for (int i = 0; i < 100 && !idle; i++) begin
      step();
      if (busy) n++; else idle = 1;
    end
    chk({tag, " busy length"}, n, CONV);
    chk({tag, " done strobe"}, conv_done, 1);
    step();
    chk({tag, " done one cycle"}, conv_done, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 presc_rst", presc_rst, 0);
    chk("R1 conv_done", conv_done, 0);
    chk("R1 sense_temp", sense_temp, 0);
    chk("R1 conv_ch", conv_ch, 0);
  endtask

  task automatic t_sw_start();
    enable = 1; ch_sel = 6'd3; start_wr = 1; step(); start_wr = 0;
    chk("R2 busy", busy, 1);
    chk("R2 conv_start", conv_start, 1);
    chk("R5 no presc on sw start", presc_rst, 0);
    step();
    chk("R2 start one cycle", conv_start, 0);
    finish_conv("R2", 2);
  endtask

  task automatic t_disabled();
    enable = 0; auto_en = 1; trig_sel = 3'd1; trig_in = 0; step();
    start_wr = 1; trig_in[1] = 1; step(); start_wr = 0;
    chk("R3 no start when disabled", busy, 0);
    step();
    chk("R3 no start pulse", conv_start, 0);
    trig_in = 0; auto_en = 0; enable = 1; step();
  endtask

  task automatic t_channel();
    ch_sel = 6'd9; start_wr = 1; step(); start_wr = 0;
    chk("R4 latched", conv_ch, 9);
    ch_sel = 6'd17; step(); step();
    chk("R4 held during conversion", conv_ch, 9);
    finish_conv("R4", 3);
    chk("R4 idle keeps old", conv_ch, 9);
    start_wr = 1; step(); start_wr = 0;
    chk("R4 new channel next conv", conv_ch, 17);
    finish_conv("R4b", 1);
  endtask

  task automatic t_auto();
    auto_en = 1; trig_sel = 3'd5; trig_in = 0; step();
    trig_in[2] = 1; step();
    chk("R8 unselected line ignored", busy, 0);
    trig_in[5] = 1; step();
    chk("R5 trigger start", busy, 1);
    chk("R5 start pulse", conv_start, 1);
    chk("R5 prescaler reset", presc_rst, 1);
    trig_in[5] = 0; step();
    chk("R5 presc one cycle", presc_rst, 0);
    // R6: edge made mid-conversion is ignored
    trig_in[5] = 1; step();
    chk("R6 no restart pulse", conv_start, 0);
    trig_in = 0;
    finish_conv("R6", 3);
  endtask

  task automatic t_held();
    trig_sel = 3'd0; trig_in = 0; step();
    trig_in[0] = 1; step();
    chk("R7 first start", conv_start, 1);
    finish_conv("R7", 1);
    step(); step();
    chk("R7 held high no restart", busy, 0);
    trig_in[0] = 0; step();
    trig_in[0] = 1; step();
    chk("R7 fresh edge restarts", busy, 1);
    finish_conv("R7b", 1);
    trig_in = 0; step();
  endtask

  task automatic t_auto_off();
    auto_en = 0; trig_sel = 3'd4; step();
    trig_in[4] = 1; step(); step();
    chk("R8 auto off ignores edge", busy, 0);
    trig_in = 0; step();
  endtask

  task automatic t_abort();
    int seen = 0;
    start_wr = 1; step(); start_wr = 0;
    step(); step(); step();
    enable = 0; step();
    chk("R9 busy dropped", busy, 0);
    enable = 1;
    for (int i = 0; i < CONV + 2; i++) begin
      step();
      seen += conv_done;
    end
    chk("R9 no done after abort", seen, 0);
  endtask

  task automatic t_temp();
    ch_sel = 6'b100010; start_wr = 1; step(); start_wr = 0;
    chk("R10 temp active", sense_temp, 1);
    ch_sel = 6'd5; step();
    chk("R10 temp held", sense_temp, 1);
    finish_conv("R10", 2);
    chk("R10 temp off when idle", sense_temp, 0);
    start_wr = 1; step(); start_wr = 0;
    chk("R10 other channel", sense_temp, 0);
    finish_conv("R10b", 1);
  endtask

  task automatic t_restart_ignored();
    start_wr = 1; step(); start_wr = 0;
    step(); step(); step(); step();
    start_wr = 1; step(); start_wr = 0;
    chk("R11 no restart pulse", conv_start, 0);
    finish_conv("R11", 6);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1; step();
    t_sw_start();
    t_disabled();
    t_channel();
    t_auto();
    t_held();
    t_auto_off();
    t_abort();
    t_temp();
    t_restart_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule